// File: doc/BRIEF.md
# Multi-Source Memory-Backed Event Counter

This block keeps a bank of event counters in synchronous dual-port RAM instead of flip-flops. Three independent increment sources and one read requester each present a single-cycle pulse together with a counter index. A small controller shares the RAM among them. It runs a fixed four-cycle rotation with one slot per requester. In a source's slot, the controller does a read-modify-write that adds one to the selected counter. In the read slot, it fetches the counter and returns it on a data output, marked by a one-cycle strobe.

Each counter is stored as two equal halves, each in its own RAM. The increment carries from the lower half into the upper half. Every request pin passes through a flip-flop, and so does every output. After the active-low reset is released, the block writes zero to every entry, one entry per cycle. Only then does it raise its ready flag and begin serving requests. Each request input may pulse at most once every four cycles. A request that arrives outside its own slot is held until that slot comes round.

Top module: `evt_stat_counter`

## Requirements
- R1: The block holds NUM_CNT counters (default 256, index width log2 of that), each 2*HALF_W bits wide (default 32). A strobed read of an index returns the number of increments serviced on that index since the clear, modulo 2^(2*HALF_W).
- R2: After rst_n is released, ready_o stays 0 for NUM_CNT-1 rising edges and reads 1 after the NUM_CNT-th edge. It then stays 1 until reset. Every counter reads 0 at that point.
- R3: A request pulse sampled by a clock edge that comes before the edge at which ready_o rises is discarded. It changes no counter and produces no strobe.
- R4: Number the cycles after the rising edge of ready_o as 0, 1, 2 and so on. Cycle c serves slot c mod 4, where slot 0 is source A, 1 is source B, 2 is source C and 3 is the read port. A pulse sampled at the edge that starts cycle j is served in the first cycle k >= j+1 that belongs to its slot.
- R5: A read served in cycle k drives rd_strobe_o high for exactly cycle k+2, with the value on rd_data_o during that cycle. This gives 3 to 6 rising edges from the edge that sampled the pulse to the strobe.
- R6: Each port accepts a pulse every fourth cycle with none lost, including when all four ports pulse in the same cycle.
- R7: An increment adds one across both halves, carrying from the lower half into the upper half. The all-ones value wraps to zero.
- R8: A read or increment served in the cycle right after an increment of the same index sees the incremented value, even though that write has not yet reached the RAM.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| inc_a_i | input | 1 | Increment pulse, source A |
| inc_a_idx_i | input | IW | Counter index for source A |
| inc_b_i | input | 1 | Increment pulse, source B |
| inc_b_idx_i | input | IW | Counter index for source B |
| inc_c_i | input | 1 | Increment pulse, source C |
| inc_c_idx_i | input | IW | Counter index for source C |
| rd_req_i | input | 1 | Read request pulse |
| rd_idx_i | input | IW | Counter index to read |
| rd_data_o | output | 2*HALF_W | Counter value returned by a read |
| rd_strobe_o | output | 1 | High for one cycle while rd_data_o is valid |
| ready_o | output | 1 | High once the clear sweep has finished |

## Verification
Two functions can meet on one counter in a single cycle. An increment's write-back can land in the same cycle as the next slot's RAM read of that counter, so the forwarded value has to win over the stale RAM word. The bench provokes this by pulsing source C and the read port on one index in the same cycle, by hammering a single index from all three sources at full rate, and by random traffic over a small 16-entry, 8-bit configuration. A reference model in the bench computes each service cycle from the slot rule. Each strobed value is judged against the model's count at the read's service cycle, and so is the exact strobe cycle.

// File: rtl/esc_pkg.sv
`timescale 1ns/1ps
package esc_pkg;
  localparam int unsigned NUM_PORTS = 4;
  localparam int unsigned SLOT_W    = 2;

  typedef enum logic [SLOT_W-1:0] {
    SLOT_SRC_A = 2'd0,
    SLOT_SRC_B = 2'd1,
    SLOT_SRC_C = 2'd2,
    SLOT_READ  = 2'd3
  } slot_e;
endpackage

// File: rtl/esc_dp_ram.sv
`timescale 1ns/1ps
module esc_dp_ram #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rd_en_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] rd_q;

  // port B: write; port A: registered read (old data on same-edge collision)
  always_ff @(posedge clk) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  always_ff @(posedge clk) begin
    if (rd_en_i) rd_q <= mem_q[rd_addr_i];
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/esc_req_port.sv
`timescale 1ns/1ps
module esc_req_port #(
  parameter int unsigned IW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pulse_i,
  input  logic [IW-1:0] idx_i,
  input  logic          accept_i,
  input  logic          done_i,
  output logic          pend_o,
  output logic [IW-1:0] idx_o
);
  logic          pulse_q;
  logic [IW-1:0] idx_q;
  logic          pend_q, pend_d;
  logic [IW-1:0] cap_q, cap_d;
  logic          idx_en;

  assign idx_en = pulse_i;

  // input flops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      idx_q   <= '0;
    end else begin
      pulse_q <= pulse_i;
      if (idx_en) idx_q <= idx_i;
    end
  end

  // pending capture: a new request wins over the clear of the old one
  always_comb begin
    pend_d = pend_q;
    cap_d  = cap_q;
    if (done_i) pend_d = 1'b0;
    if (pulse_q && accept_i) begin
      pend_d = 1'b1;
      cap_d  = idx_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cap_q  <= '0;
    end else begin
      pend_q <= pend_d;
      cap_q  <= cap_d;
    end
  end

  assign pend_o = pend_q;
  assign idx_o  = cap_q;

  AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q && accept_i) |=> (pend_q && cap_q == $past(idx_q))); // R6
  AST_DROP_UNREADY: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q && !accept_i && !pend_q) |=> !pend_q); // R3
endmodule

// File: rtl/esc_ctrl.sv
`timescale 1ns/1ps
module esc_ctrl
  import esc_pkg::*;
#(
  parameter int unsigned IW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              ready_o,
  output logic              clr_we_o,
  output logic [IW-1:0]     clr_addr_o,
  output logic [SLOT_W-1:0] slot_o
);
  logic              clearing_q, clearing_d;
  logic              ready_q, ready_d;
  logic [IW-1:0]     clr_cnt_q, clr_cnt_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              clr_en, slot_en;

  assign clr_en  = clearing_q;
  assign slot_en = ready_q;

  always_comb begin
    clearing_d = clearing_q;
    ready_d    = ready_q;
    clr_cnt_d  = clr_cnt_q;
    slot_d     = slot_q;
    if (clr_en) begin
      clr_cnt_d = clr_cnt_q + 1'b1;
      if (clr_cnt_q == {IW{1'b1}}) begin
        clearing_d = 1'b0;
        ready_d    = 1'b1;
      end
    end
    if (slot_en) slot_d = slot_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clearing_q <= 1'b1;
      ready_q    <= 1'b0;
      clr_cnt_q  <= '0;
      slot_q     <= SLOT_W'(SLOT_SRC_A);
    end else begin
      clearing_q <= clearing_d;
      ready_q    <= ready_d;
      clr_cnt_q  <= clr_cnt_d;
      slot_q     <= slot_d;
    end
  end

  assign ready_o    = ready_q;
  assign clr_we_o   = clearing_q;
  assign clr_addr_o = clr_cnt_q;
  assign slot_o     = slot_q;

  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |=> ready_q); // R2
  AST_CLEAR_DONE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |-> !clearing_q); // R2
  AST_SLOT_START_A: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_q) |-> (slot_q == SLOT_W'(SLOT_SRC_A))); // R4
endmodule

// File: rtl/esc_incr.sv
`timescale 1ns/1ps
module esc_incr #(
  parameter int unsigned HALF_W = 16,
  parameter int unsigned HALVES = 2
) (
  input  logic [HALVES*HALF_W-1:0] val_i,
  output logic [HALVES*HALF_W-1:0] res_o
);
  logic [HALVES:0] carry;

  assign carry[0] = 1'b1;

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    logic [HALF_W-1:0] half_in;
    assign half_in = val_i[h*HALF_W +: HALF_W];
    assign res_o[h*HALF_W +: HALF_W] = half_in + {{(HALF_W-1){1'b0}}, carry[h]};
    assign carry[h+1] = carry[h] & (&half_in);
  end

  always_comb begin
    if (&val_i) begin
      AST_WRAP_ZERO: assert (res_o == '0); // R7
    end else begin
      AST_NONZERO_SUCC: assert (res_o != '0); // R7
    end
  end
endmodule

// File: rtl/evt_stat_counter.sv
`timescale 1ns/1ps
module evt_stat_counter
  import esc_pkg::*;
#(
  parameter int unsigned NUM_CNT    = 256,
  parameter int unsigned HALF_W     = 16,
  parameter int unsigned CNT_HALVES = 2,
  localparam int unsigned IW = $clog2(NUM_CNT),
  localparam int unsigned CW = CNT_HALVES * HALF_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc_a_i,
  input  logic [IW-1:0] inc_a_idx_i,
  input  logic          inc_b_i,
  input  logic [IW-1:0] inc_b_idx_i,
  input  logic          inc_c_i,
  input  logic [IW-1:0] inc_c_idx_i,
  input  logic          rd_req_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [CW-1:0] rd_data_o,
  output logic          rd_strobe_o,
  output logic          ready_o
);
  localparam int unsigned NP = NUM_PORTS;

  // control
  logic              ready;
  logic              clr_we;
  logic [IW-1:0]     clr_addr;
  logic [SLOT_W-1:0] slot_q;

  esc_ctrl #(.IW(IW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ready_o    (ready),
    .clr_we_o   (clr_we),
    .clr_addr_o (clr_addr),
    .slot_o     (slot_q)
  );

  // request capture
  logic [NP-1:0] req_pulse;
  logic [IW-1:0] req_idx [NP];
  logic [NP-1:0] pend;
  logic [IW-1:0] cap_idx [NP];
  logic [NP-1:0] svc_done;

  assign req_pulse  = {rd_req_i, inc_c_i, inc_b_i, inc_a_i};
  assign req_idx[0] = inc_a_idx_i;
  assign req_idx[1] = inc_b_idx_i;
  assign req_idx[2] = inc_c_idx_i;
  assign req_idx[3] = rd_idx_i;

  for (genvar p = 0; p < NP; p++) begin : g_port
    assign svc_done[p] = ready && (slot_q == SLOT_W'(p));
    esc_req_port #(.IW(IW)) u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .pulse_i  (req_pulse[p]),
      .idx_i    (req_idx[p]),
      .accept_i (ready),
      .done_i   (svc_done[p]),
      .pend_o   (pend[p]),
      .idx_o    (cap_idx[p])
    );
  end

  // service stage 0: issue RAM read
  logic          svc_valid;
  logic          svc_read;
  logic [IW-1:0] svc_addr;

  assign svc_valid = pend[slot_q];
  assign svc_read  = (slot_q == SLOT_W'(SLOT_READ));
  assign svc_addr  = cap_idx[slot_q];

  // service stage 1: modify and write back or return
  logic          s1_valid_q, s1_valid_d;
  logic          s1_read_q, s1_read_d;
  logic [IW-1:0] s1_addr_q, s1_addr_d;
  logic          fwd_hit_q, fwd_hit_d;
  logic [CW-1:0] fwd_val_q;
  logic          fwd_en;
  logic [CW-1:0] ram_rd;
  logic [CW-1:0] cur_val;
  logic [CW-1:0] inc_val;
  logic          s1_inc;

  assign s1_inc  = s1_valid_q && !s1_read_q;
  assign cur_val = fwd_hit_q ? fwd_val_q : ram_rd;

  esc_incr #(.HALF_W(HALF_W), .HALVES(CNT_HALVES)) u_incr (
    .val_i (cur_val),
    .res_o (inc_val)
  );

  always_comb begin
    s1_valid_d = svc_valid;
    s1_read_d  = svc_read;
    s1_addr_d  = svc_addr;
    // a write landing on the edge that reads the same entry must be bypassed
    fwd_hit_d  = svc_valid && s1_inc && (s1_addr_q == svc_addr);
  end

  assign fwd_en = fwd_hit_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid_q <= 1'b0;
      s1_read_q  <= 1'b0;
      s1_addr_q  <= '0;
      fwd_hit_q  <= 1'b0;
      fwd_val_q  <= '0;
    end else begin
      s1_valid_q <= s1_valid_d;
      s1_read_q  <= s1_read_d;
      s1_addr_q  <= s1_addr_d;
      fwd_hit_q  <= fwd_hit_d;
      if (fwd_en) fwd_val_q <= inc_val;
    end
  end

  // storage: one RAM per counter half
  logic          wr_en;
  logic [IW-1:0] wr_addr;
  logic [CW-1:0] wr_data;

  assign wr_en   = clr_we || s1_inc;
  assign wr_addr = clr_we ? clr_addr : s1_addr_q;
  assign wr_data = clr_we ? '0 : inc_val;

  for (genvar h = 0; h < CNT_HALVES; h++) begin : g_ram
    esc_dp_ram #(.AW(IW), .DW(HALF_W)) u_ram (
      .clk       (clk),
      .rd_en_i   (svc_valid),
      .rd_addr_i (svc_addr),
      .rd_data_o (ram_rd[h*HALF_W +: HALF_W]),
      .wr_en_i   (wr_en),
      .wr_addr_i (wr_addr),
      .wr_data_i (wr_data[h*HALF_W +: HALF_W])
    );
  end

  // output flops
  logic [CW-1:0] out_data_q, out_data_d;
  logic          out_stb_q, out_stb_d;
  logic          out_en;

  assign out_en = s1_valid_q && s1_read_q;

  always_comb begin
    out_stb_d  = out_en;
    out_data_d = out_en ? cur_val : out_data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_stb_q  <= 1'b0;
      out_data_q <= '0;
    end else begin
      out_stb_q  <= out_stb_d;
      out_data_q <= out_data_d;
    end
  end

  assign rd_data_o   = out_data_q;
  assign rd_strobe_o = out_stb_q;
  assign ready_o     = ready;

  AST_NO_SVC_BEFORE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !svc_valid); // R3
  AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |-> !s1_valid_q); // R2
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_stb_q |=> !out_stb_q); // R5
  AST_STROBE_FROM_READ_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    out_stb_q |-> ($past(svc_valid, 2) && $past(slot_q, 2) == SLOT_W'(SLOT_READ))); // R4
  AST_WRITE_FROM_INC_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    s1_inc |-> ($past(svc_valid) && $past(slot_q) != SLOT_W'(SLOT_READ))); // R1
  AST_FWD_AFTER_INC: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_hit_q |-> $past(s1_inc)); // R8
endmodule

// File: tb/evt_stat_counter_bench.sv
`timescale 1ns/1ps
module evt_stat_counter_bench;
  localparam int N    = 16;
  localparam int HW   = 4;
  localparam int CW   = 2 * HW;
  localparam int IW   = 4;
  localparam int MASK = (1 << CW) - 1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic inc_a, inc_b, inc_c, rd_req;
  logic [IW-1:0] idx_a, idx_b, idx_c, idx_r;
  logic [CW-1:0] rd_data;
  logic rd_strobe, ready;

  evt_stat_counter #(.NUM_CNT(N), .HALF_W(HW), .CNT_HALVES(2)) u_evt_stat_counter (
    .clk(clk), .rst_n(rst_n),
    .inc_a_i(inc_a), .inc_a_idx_i(idx_a),
    .inc_b_i(inc_b), .inc_b_idx_i(idx_b),
    .inc_c_i(inc_c), .inc_c_idx_i(idx_c),
    .rd_req_i(rd_req), .rd_idx_i(idx_r),
    .rd_data_o(rd_data), .rd_strobe_o(rd_strobe), .ready_o(ready)
  );

  typedef struct { int k; int idx; int j; } pend_t;
  typedef struct { int cyc; int val; int j; int idx; } exp_t;

  pend_t pq0[$], pq1[$], pq2[$], pq3[$];
  exp_t  eq[$];
  int    ref_mem [N];
  int    last_j [4];
  int    cyc;
  int    checks = 0;
  int    fails  = 0;
  string tag    = "R1";
  bit    done   = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, expv, cyc);
    end
  endtask

  function automatic bit can_pulse(input int s);
    return (cyc + 1 - last_j[s]) >= 4;
  endfunction

  task automatic pulse(input int s, input int idx);
    int j, d, k;
    pend_t e;
    j = cyc + 1;
    case (s)
      0: begin inc_a = 1'b1; idx_a = IW'(idx); end
      1: begin inc_b = 1'b1; idx_b = IW'(idx); end
      2: begin inc_c = 1'b1; idx_c = IW'(idx); end
      default: begin rd_req = 1'b1; idx_r = IW'(idx); end
    endcase
    last_j[s] = j;
    if (j >= 1) begin
      d = (s - (j + 1)) % 4;
      if (d < 0) d += 4;
      k = j + 1 + d;
      e = '{k, idx, j};
      case (s)
        0: pq0.push_back(e);
        1: pq1.push_back(e);
        2: pq2.push_back(e);
        default: pq3.push_back(e);
      endcase
    end
  endtask

  task automatic serve(input int s);
    pend_t e;
    bit hit;
    hit = 1'b0;
    case (s)
      0: if (pq0.size() > 0 && pq0[0].k == cyc) begin e = pq0.pop_front(); hit = 1'b1; end
      1: if (pq1.size() > 0 && pq1[0].k == cyc) begin e = pq1.pop_front(); hit = 1'b1; end
      2: if (pq2.size() > 0 && pq2[0].k == cyc) begin e = pq2.pop_front(); hit = 1'b1; end
      default: if (pq3.size() > 0 && pq3[0].k == cyc) begin e = pq3.pop_front(); hit = 1'b1; end
    endcase
    if (hit) begin
      if (s < 3) ref_mem[e.idx] = (ref_mem[e.idx] + 1) & MASK;
      else eq.push_back('{cyc + 2, ref_mem[e.idx], e.j, e.idx});
    end
  endtask

  task automatic tick();
    exp_t x;
    @(posedge clk);
    #1;
    cyc++;
    if (cyc == -1) check(ready === 1'b0, "R2", "ready one edge early", int'(ready), 0);
    else if (cyc == 0) check(ready === 1'b1, "R2", "ready at clear end", int'(ready), 1);
    else if (cyc > 0 && ready !== 1'b1) check(1'b0, "R2", "ready dropped", int'(ready), 1);
    if (cyc >= 0) serve(cyc % 4);
    if (eq.size() > 0 && eq[0].cyc == cyc) begin
      x = eq.pop_front();
      check(rd_strobe === 1'b1, "R5", "strobe cycle", int'(rd_strobe), 1);
      check(int'(rd_data) == x.val, tag, $sformatf("read value idx %0d", x.idx),
            int'(rd_data), x.val);
      check((cyc - x.j) >= 3 && (cyc - x.j) <= 6, "R5", "read latency", cyc - x.j, 3);
    end else if (rd_strobe !== 1'b0) begin
      check(1'b0, "R5", "spurious strobe", int'(rd_strobe), 0);
    end
    inc_a = 1'b0; inc_b = 1'b0; inc_c = 1'b0; rd_req = 1'b0;
  endtask

  task automatic read_all(input string t);
    tag = t;
    for (int i = 0; i < N; i++) begin
      while (!can_pulse(3)) tick();
      pulse(3, i);
      tick();
    end
  endtask

  task automatic drain(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    rst_n = 1'b0;
    inc_a = 1'b0; inc_b = 1'b0; inc_c = 1'b0; rd_req = 1'b0;
    idx_a = '0; idx_b = '0; idx_c = '0; idx_r = '0;
    for (int i = 0; i < N; i++) ref_mem[i] = 0;
    for (int i = 0; i < 4; i++) last_j[i] = -1000;
    cyc = -1000;
    repeat (3) @(posedge clk);
    #1;
    check(ready === 1'b0, "R2", "reset ready", int'(ready), 0);
    check(rd_strobe === 1'b0, "R5", "reset strobe", int'(rd_strobe), 0);
    check(rd_data == '0, "R1", "reset data", int'(rd_data), 0);
    cyc = -N;
    rst_n = 1'b1;

    // R3: requests during the clear sweep are dropped
    tag = "R3";
    while (cyc < -1) begin
      if (cyc < -3)
        for (int s = 0; s < 4; s++)
          if (can_pulse(s)) pulse(s, (cyc + s) & (N - 1));
      tick();
    end
    tick();

    // R2: every counter cleared; also confirms R3 drops
    read_all("R2");
    drain(8);

    // R4: single reads at each phase of the rotation
    tag = "R4";
    for (int ph = 0; ph < 8; ph++) begin
      for (int w = 0; w < ph + 4; w++) tick();
      pulse(3, ph);
      tick();
    end
    drain(8);

    // R1: random traffic on all ports
    tag = "R1";
    for (int t = 0; t < 3000; t++) begin
      for (int s = 0; s < 4; s++)
        if (can_pulse(s) && ($urandom % 2 == 0)) pulse(s, int'($urandom % N));
      tick();
    end
    drain(8);

    // R6: all four ports at full rate in the same cycle
    tag = "R6";
    for (int t = 0; t < 240; t++) begin
      for (int s = 0; s < 4; s++)
        if (can_pulse(s)) pulse(s, (cyc / 8) & (N - 1));
      tick();
    end
    drain(8);

    // R8: increment and read of one index in the same cycle
    tag = "R8";
    for (int t = 0; t < 200; t++) begin
      if (can_pulse(2) && can_pulse(3)) begin
        pulse(2, 3 + (t % 2));
        pulse(3, 3 + (t % 2));
      end
      if (can_pulse(0) && (t % 3 == 0)) pulse(0, 3);
      tick();
    end
    drain(8);

    // R7: hammer one index across the half boundary and through wrap
    tag = "R7";
    for (int t = 0; t < 1200; t++) begin
      for (int s = 0; s < 3; s++)
        if (can_pulse(s)) pulse(s, 9);
      if (can_pulse(3) && (t % 12 == 1)) pulse(3, 9);
      tick();
    end
    drain(8);

    read_all("R1");
    drain(12);
    check(eq.size() == 0, "R5", "reads without strobe", eq.size(), 0);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule